// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block sits beside a small 8-bit CPU core and takes over at an instruction boundary when an interrupt must be taken. It watches one non-maskable request line and eight maskable request lines. Each maskable line has its own enable bit. At each boundary that the core reports, the block picks the most urgent request that may be taken. It then stalls the core and runs the entry sequence on a word-wide memory port.

The entry sequence first pushes the return address and then the condition-code byte onto a descending stack. It then raises the global mask bit and reads the handler address from a vector table. Finally it hands that address to the core as the new program counter. The core owns its program counter, condition-code register and stack pointer. The block reads their current values at acceptance and returns the updated values through write strobes.

Top module: `irq_entry_seq`

## Requirements
- R1: The non-maskable input is latched on its rising edge. One rising edge yields exactly one entry sequence, even if the input stays high. The latch clears when that sequence is accepted.
- R2: A maskable request on line i counts only while `irq_en[i]` is 1. With the enable bit at 0, the request never starts a sequence.
- R3: Priority is fixed. The non-maskable source (slot 0) wins over all others, then line 0 (slot 1) down to line 7 (slot 8). `src_slot` reports the slot of the sequence in progress. Requests that lose stay pending and are taken at a later boundary.
- R4: Maskable requests are taken only while bit 7 (the I bit) of `ccr_in` is 0. While it is 1 they are held. A latched non-maskable request is taken whatever the I bit holds.
- R5: Acceptance happens only in a cycle where `insn_done` is 1. `busy` is 1 from the next cycle for exactly four cycles.
- R6: A boundary marked with `ccr_write`=1 never accepts. The same request is taken at the next unmarked boundary.
- R7: The first busy cycle writes `next_pc` to address `sp_in`-2. The second writes {8'h00, `ccr_in`} to address `sp_in`-4. Both values are the ones sampled at acceptance.
- R8: In the third busy cycle, `ccr_we` pulses with `ccr_out` equal to the sampled CCR with bit 7 set. In the same cycle, `sp_we` pulses with `sp_out` equal to `sp_in`-4.
- R9: The third busy cycle also reads address 2×slot. In the fourth cycle, `pc_load` pulses with `pc_new` equal to the word returned by that read. Memory returns read data one cycle after the request.
- R10: While `busy` is 1, no boundary is accepted. `busy` falls in the cycle after `pc_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_in | input | 1 | Non-maskable request, edge-latched |
| irq_req | input | 8 | Maskable request levels, line 0 most urgent |
| irq_en | input | 8 | Per-line enable bits |
| insn_done | input | 1 | Core reports an instruction boundary this cycle |
| ccr_write | input | 1 | The finishing instruction modified the CCR |
| next_pc | input | 16 | Address of the next instruction to run |
| ccr_in | input | 8 | Current CCR, bit 7 is the global mask |
| sp_in | input | 16 | Current stack pointer |
| mem_rdata | input | 16 | Read data, valid one cycle after a read |
| busy | output | 1 | Stall to the core during the entry sequence |
| src_slot | output | 4 | Slot of the source being serviced |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| ccr_we | output | 1 | Load `ccr_out` into the core CCR |
| ccr_out | output | 8 | New CCR value |
| sp_we | output | 1 | Load `sp_out` into the core stack pointer |
| sp_out | output | 16 | New stack pointer value |
| pc_load | output | 1 | Load `pc_new` into the core program counter |
| pc_new | output | 16 | Handler address |

## Verification
The assertions assume that the memory returns read data exactly one cycle after each read strobe. They also assume that the core keeps `ccr_in` and `sp_in` unchanged while `busy` is 1. The bench models a core and a vector memory that meet both conditions. It changes the core's CCR and stack pointer only between sequences. It pulses `nmi_in` only while the block is idle, so that the bench's own pending-request model stays exact. Random request, enable and mask patterns are mixed with boundaries marked as CCR writes. Each expected slot comes from a priority function in the bench.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_IRQ = 8;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 16;
    localparam int CCR_W   = 8;
    localparam int IBIT    = 7;
    localparam int SLOTS   = NUM_IRQ + 1;
    localparam int SLOT_W  = $clog2(SLOTS);
    localparam int WORD_B  = DATA_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PC,
        ST_PUSH_CCR,
        ST_VECTOR,
        ST_LOAD
    } seq_state_e;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [ADDR_W-1:0] ret_pc;
        logic [CCR_W-1:0]  ccr;
    } entry_ctx_t;

    function automatic logic [ADDR_W-1:0] vector_addr(input logic [SLOT_W-1:0] s);
        return ADDR_W'(s) * ADDR_W'(WORD_B);
    endfunction
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic nmi_in,
    input  logic clr,
    output logic pend
);
    logic nmi_q;
    logic rise;

    assign rise = nmi_in && !nmi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            nmi_q <= nmi_in;
            pend  <= rise || (pend && !clr);
        end
    end

    p_nmi_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (pend && !clr) |=> pend);
    p_nmi_clear_r1: assert property (@(posedge clk) disable iff (rst)
        (clr && !rise) |=> !pend);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_pkg::*;
(
    input  logic               nmi_pend,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               i_mask,
    output logic               win_valid,
    output logic [SLOT_W-1:0]  win_slot
);
    logic [NUM_IRQ-1:0] live;

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_live
        assign live[g] = irq_req[g] && irq_en[g] && !i_mask;
    end

    always_comb begin
        win_valid = 1'b0;
        win_slot  = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (live[i]) begin
                win_valid = 1'b1;
                win_slot  = SLOT_W'(i + 1);
            end
        end
        if (nmi_pend) begin
            win_valid = 1'b1;
            win_slot  = '0;
        end
    end
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              insn_done,
    input  logic              ccr_write,
    input  logic              win_valid,
    input  logic [SLOT_W-1:0] win_slot,
    input  logic [ADDR_W-1:0] next_pc,
    input  logic [CCR_W-1:0]  ccr_in,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              accept,
    output logic              busy,
    output logic [SLOT_W-1:0] src_slot,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              ccr_we,
    output logic [CCR_W-1:0]  ccr_out,
    output logic              sp_we,
    output logic [ADDR_W-1:0] sp_out,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_new
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_B);

    seq_state_e        state;
    entry_ctx_t        ctx;
    logic [ADDR_W-1:0] sp_cur;

    assign accept   = (state == ST_IDLE) && insn_done && !ccr_write && win_valid;
    assign busy     = (state != ST_IDLE);
    assign src_slot = ctx.slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            ctx    <= '0;
            sp_cur <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    ctx.slot   <= win_slot;
                    ctx.ret_pc <= next_pc;
                    ctx.ccr    <= ccr_in;
                    sp_cur     <= sp_in;
                    state      <= ST_PUSH_PC;
                end
                ST_PUSH_PC: begin
                    sp_cur <= sp_cur - STEP;
                    state  <= ST_PUSH_CCR;
                end
                ST_PUSH_CCR: begin
                    sp_cur <= sp_cur - STEP;
                    state  <= ST_VECTOR;
                end
                ST_VECTOR: state <= ST_LOAD;
                ST_LOAD:   state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        ccr_we    = 1'b0;
        ccr_out   = ctx.ccr;
        sp_we     = 1'b0;
        sp_out    = sp_cur;
        pc_load   = 1'b0;
        pc_new    = '0;
        unique case (state)
            ST_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_cur - STEP;
                mem_wdata = DATA_W'(ctx.ret_pc);
            end
            ST_PUSH_CCR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_cur - STEP;
                mem_wdata = DATA_W'(ctx.ccr);
            end
            ST_VECTOR: begin
                mem_req  = 1'b1;
                mem_addr = vector_addr(ctx.slot);
                ccr_we   = 1'b1;
                ccr_out  = ctx.ccr | CCR_W'(1 << IBIT);
                sp_we    = 1'b1;
            end
            ST_LOAD: begin
                pc_load = 1'b1;
                pc_new  = ADDR_W'(mem_rdata);
            end
            default: ;
        endcase
    end

    p_accept_busy_r5: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);
    p_boundary_only_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy && !insn_done) |=> !busy);
    p_ccrwr_block_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && ccr_write) |=> !busy);
    p_mask_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && ccr_in[IBIT]) |=> (src_slot == '0));
    p_push_order_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && $past(!busy)) |=> (mem_we && mem_addr == $past(mem_addr) - STEP));
    p_ibit_set_r8: assert property (@(posedge clk) disable iff (rst)
        ccr_we |-> (ccr_out[IBIT] && sp_we));
    p_vec_even_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> (mem_addr[0] == 1'b0));
    p_load_after_read_r9: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> $past(mem_req && !mem_we));
    p_release_r10: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> !busy);
    p_single_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_we, pc_load, ccr_we}));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               nmi_in,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               insn_done,
    input  logic               ccr_write,
    input  logic [ADDR_W-1:0]  next_pc,
    input  logic [CCR_W-1:0]   ccr_in,
    input  logic [ADDR_W-1:0]  sp_in,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               busy,
    output logic [SLOT_W-1:0]  src_slot,
    output logic               mem_req,
    output logic               mem_we,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               ccr_we,
    output logic [CCR_W-1:0]   ccr_out,
    output logic               sp_we,
    output logic [ADDR_W-1:0]  sp_out,
    output logic               pc_load,
    output logic [ADDR_W-1:0]  pc_new
);
    logic              nmi_pend;
    logic              nmi_clr;
    logic              win_valid;
    logic [SLOT_W-1:0] win_slot;
    logic              accept;

    assign nmi_clr = accept && (win_slot == '0);

    irq_nmi_latch u_nmi (
        .clk    (clk),
        .rst    (rst),
        .nmi_in (nmi_in),
        .clr    (nmi_clr),
        .pend   (nmi_pend)
    );

    irq_prio_pick u_pick (
        .nmi_pend  (nmi_pend),
        .irq_req   (irq_req),
        .irq_en    (irq_en),
        .i_mask    (ccr_in[IBIT]),
        .win_valid (win_valid),
        .win_slot  (win_slot)
    );

    irq_entry_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .insn_done (insn_done),
        .ccr_write (ccr_write),
        .win_valid (win_valid),
        .win_slot  (win_slot),
        .next_pc   (next_pc),
        .ccr_in    (ccr_in),
        .sp_in     (sp_in),
        .mem_rdata (mem_rdata),
        .accept    (accept),
        .busy      (busy),
        .src_slot  (src_slot),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .ccr_we    (ccr_we),
        .ccr_out   (ccr_out),
        .sp_we     (sp_we),
        .sp_out    (sp_out),
        .pc_load   (pc_load),
        .pc_new    (pc_new)
    );
endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
    import irq_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               nmi_in = 1'b0;
    logic [NUM_IRQ-1:0] irq_req = '0;
    logic [NUM_IRQ-1:0] irq_en = '0;
    logic               insn_done = 1'b0;
    logic               ccr_write = 1'b0;
    logic [ADDR_W-1:0]  next_pc = '0;
    logic [CCR_W-1:0]   core_ccr = '0;
    logic [ADDR_W-1:0]  core_sp = 16'h0400;
    logic [DATA_W-1:0]  mem_rdata = '0;
    logic               busy, mem_req, mem_we, ccr_we, sp_we, pc_load;
    logic [SLOT_W-1:0]  src_slot;
    logic [ADDR_W-1:0]  mem_addr, sp_out, pc_new;
    logic [DATA_W-1:0]  mem_wdata;
    logic [CCR_W-1:0]   ccr_out;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  nmi_pend_m = 1'b0;

    always #2.5 clk = ~clk;

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst(rst), .nmi_in(nmi_in), .irq_req(irq_req), .irq_en(irq_en),
        .insn_done(insn_done), .ccr_write(ccr_write), .next_pc(next_pc),
        .ccr_in(core_ccr), .sp_in(core_sp), .mem_rdata(mem_rdata),
        .busy(busy), .src_slot(src_slot), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .ccr_we(ccr_we), .ccr_out(ccr_out),
        .sp_we(sp_we), .sp_out(sp_out), .pc_load(pc_load), .pc_new(pc_new)
    );

    function automatic logic [15:0] vec_word(input logic [15:0] a);
        return 16'h8000 ^ (a * 16'h0101) ^ 16'h0035;
    endfunction

    // vector memory: read data one cycle after request
    always_ff @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= vec_word(mem_addr);
    end

    function automatic int exp_slot(input bit np, input logic [7:0] rq,
                                    input logic [7:0] en, input bit ib);
        if (np) return 0;
        if (ib) return -1;
        for (int i = 0; i < NUM_IRQ; i++) if (rq[i] && en[i]) return i + 1;
        return -1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic nmi_pulse();
        @(negedge clk); nmi_in = 1'b1;
        @(negedge clk); nmi_in = 1'b0;
        nmi_pend_m = 1'b1;
    endtask

    task automatic boundary(input logic [15:0] pc, input bit wr, input bit noisy);
        int e;
        e = wr ? -1 : exp_slot(nmi_pend_m, irq_req, irq_en, core_ccr[IBIT]);
        @(negedge clk);
        insn_done = 1'b1; ccr_write = wr; next_pc = pc;
        @(negedge clk);
        if (!noisy) begin insn_done = 1'b0; ccr_write = 1'b0; end
        if (e < 0) begin
            chk(wr ? "R6 marked boundary blocked" : "R2/R4 no accept", busy, 0);
            insn_done = 1'b0; ccr_write = 1'b0;
            return;
        end
        chk("R5 busy after accept", busy, 1);
        chk("R3 slot", src_slot, e);
        chk("R7 pc push write", {mem_req, mem_we}, 2'b11);
        chk("R7 pc push addr", mem_addr, 16'(core_sp - 16'd2));
        chk("R7 pc push data", mem_wdata, pc);
        @(negedge clk);
        chk("R7 ccr push addr", mem_addr, 16'(core_sp - 16'd4));
        chk("R7 ccr push data", mem_wdata, {8'h00, core_ccr});
        @(negedge clk);
        chk("R9 vector read", {mem_req, mem_we, mem_addr}, {2'b10, 16'(e * 2)});
        chk("R8 ccr update", {ccr_we, ccr_out}, {1'b1, core_ccr | 8'h80});
        chk("R8 sp update", {sp_we, sp_out}, {1'b1, 16'(core_sp - 16'd4)});
        @(negedge clk);
        if (noisy) begin insn_done = 1'b0; ccr_write = 1'b0; end
        chk("R9 pc load", {pc_load, pc_new}, {1'b1, vec_word(16'(e * 2))});
        chk("R10 busy in load cycle", busy, 1);
        core_ccr = core_ccr | 8'h80;
        core_sp  = core_sp - 16'd4;
        if (e == 0) nmi_pend_m = 1'b0;
        @(negedge clk);
        chk("R10 busy released", busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R5 reset busy", busy, 0);
        chk("R7 reset mem_req", mem_req, 0);
        chk("R9 reset pc_load", pc_load, 0);
        rst = 1'b0;
        @(negedge clk);

        // R2: enable gates maskable requests
        irq_req = 8'h01; irq_en = 8'h00;
        boundary(16'h1000, 1'b0, 1'b0);
        irq_en = 8'h01;
        boundary(16'h1002, 1'b0, 1'b0);
        // R4: I bit now set, request held, taken once I clears
        boundary(16'h1004, 1'b0, 1'b0);
        core_ccr = 8'h05;
        boundary(16'h1006, 1'b0, 1'b0);
        // R3: fixed priority among several
        irq_req = 8'hA4; irq_en = 8'hFF; core_ccr = 8'h00;
        boundary(16'h2000, 1'b0, 1'b0);
        core_ccr = 8'h00; irq_req = 8'hA0;
        boundary(16'h2002, 1'b0, 1'b0);
        // R6: marked boundary blocked, next one accepts
        core_ccr = 8'h12; irq_req = 8'h80; irq_en = 8'h80;
        boundary(16'h3000, 1'b1, 1'b0);
        boundary(16'h3002, 1'b0, 1'b0);
        // R1/R4: NMI taken with I=1, one pulse one entry
        nmi_pulse();
        boundary(16'h4000, 1'b0, 1'b0);
        boundary(16'h4002, 1'b0, 1'b0);
        // R1: held-high NMI gives one entry only
        @(negedge clk); nmi_in = 1'b1; nmi_pend_m = 1'b1;
        boundary(16'h4100, 1'b0, 1'b0);
        boundary(16'h4102, 1'b0, 1'b0);
        nmi_in = 1'b0;
        // R10: boundaries during busy are ignored
        core_ccr = 8'h00; irq_req = 8'h02; irq_en = 8'h02;
        boundary(16'h5000, 1'b0, 1'b1);
        boundary(16'h5002, 1'b0, 1'b0);

        // constrained random mix
        void'($urandom(32'd1234));
        for (int it = 0; it < 150; it++) begin
            irq_req  = 8'($urandom);
            irq_en   = 8'($urandom);
            core_ccr = {($urandom % 3) == 0, 7'($urandom)};
            if (($urandom % 8) == 0) core_sp = {4'h0, 11'($urandom), 1'b0};
            if (($urandom % 6) == 0) nmi_pulse();
            boundary(16'($urandom), ($urandom % 5) == 0, ($urandom % 7) == 0);
        end
        repeat (2) @(negedge clk);
        report();
    end
endmodule